// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the D+ and D- lines of a low-speed USB link and turns each packet on them into bytes. It runs from a 12 MHz clock, which gives eight clock cycles per 1.5 Mbit/s bit. Both lines pass through a two-flop synchroniser. The receiver then locks onto the J-to-K transitions of the sync field and places its sample point about half a bit after each D- edge. Every D- transition re-aligns the bit phase, so a sender whose rate is slightly off can still be received.

Once sync has ended, each sample is NRZI decoded and stuffed bits are removed. The data bits are gathered least significant bit first. Each complete byte is announced with a one-cycle strobe and written into a byte store of fixed depth, which can be read back by address. A single-ended zero ends the packet, and a one-cycle done pulse then reports the byte count. A packet that is too short is dropped without a done pulse. A packet that is too long is aborted with an overflow pulse. A sync attempt that loses the line edges is abandoned with a sync error pulse. After any of these outcomes the receiver waits for the idle J state again.

Top module: `ls_usb_rx`

## Requirements
- R1: During reset and in the first cycle after it, `byte_vld`, `pkt_done`, `ovf_err` and `sync_err` are low. Line states are J (D- high, D+ low), K (D- low, D+ high) and SE0 (both low).
- R2: The receiver starts a packet only after it has seen J and then a K. It takes data only after two K bits in a row have been sampled at bit centre. The sync field as line states is K J K J K J K K.
- R3: Each data sample is compared with the previous D- sample: no change decodes as 1 and a change decodes as 0. Bits fill a byte least significant bit first. Each complete byte appears on `byte_data` with `byte_vld` high for one cycle.
- R4: After six decoded 1 bits in a row, the next bit is discarded. The final 1 of the sync field counts towards the run, and the rule also holds across byte boundaries.
- R5: An SE0 sample in bit slot 1 to 7 of a byte, or two SE0 samples in a row, ends the packet. `pkt_done` then pulses for one cycle with `pkt_len` equal to the number of complete bytes. Bits of an unfinished byte are dropped.
- R6: A single SE0 sample in bit slot 0 of a byte does not end the packet. It is decoded as a K-level data bit.
- R7: A packet that ends with fewer than `MIN_LEN` (3) complete bytes raises no `pkt_done`.
- R8: A packet with exactly `DEPTH` bytes completes normally. When byte `DEPTH`+1 completes, `ovf_err` pulses, that byte is not strobed, and no `pkt_done` follows.
- R9: After a mid-sync J bit, the next K edge must arrive within `EDGE_WIN` cycles. Otherwise `sync_err` pulses once and no byte is produced.
- R10: A single K followed by J during sync restarts the edge search. Any number of extra K J pairs before the final K K still leads to a correct lock.
- R11: Byte i of the current packet is stored at address i. `rd_data` shows the byte at `rd_addr` combinationally.
- R12: The bit phase is re-aligned on every D- transition. Packets sent with 7-cycle or 9-cycle bit periods and frequent transitions decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz receive clock |
| rst_n | input | 1 | synchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| byte_vld | output | 1 | one-cycle strobe for a completed byte |
| byte_data | output | 8 | the completed byte |
| pkt_done | output | 1 | one-cycle pulse for an accepted packet |
| pkt_len | output | $clog2(DEPTH+1) | byte count of the accepted packet |
| ovf_err | output | 1 | one-cycle pulse when a packet exceeds DEPTH bytes |
| sync_err | output | 1 | one-cycle pulse when sync edge search times out |
| rd_addr | input | $clog2(DEPTH) | byte store read address |
| rd_data | output | 8 | byte store read data |

## Verification
The bench builds the receiver with `DEPTH` set to 6 and the other parameters at their defaults (`OSR` 8, `MIN_LEN` 3, `EDGE_WIN` 10). The small depth puts both sides of the overflow limit within reach using short packets: six bytes are accepted and seven are aborted. Because the oversampling factor stays at 8, the bench can stretch and shrink the bit period by one cycle, which moves the sample point off centre within a few bits unless the phase re-aligns on edges. The ten-cycle window lets a normal sync pass at every tested bit period, while a line held at J ends in a sync error.

// File: rtl/ls_usb_rx_pkg.sv
// Package: shared types of the low-speed receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package ls_usb_rx_pkg;
    typedef enum logic [2:0] {
        ST_WAITJ,   // wait for idle J
        ST_ARM,     // idle seen, wait for first K
        ST_SYNC,    // inside sync, sampling bit centres
        ST_HUNT,    // mid-sync J seen, waiting for next K edge
        ST_DATA     // packet payload
    } rx_state_t;

    localparam int unsigned STUFF_RUN = 6;
endpackage

// File: rtl/ls_usb_rx_sync2.sv
// Module: two-flop synchroniser for a small bus of line inputs.
// Assumes: each bit is sampled independently; RST_VAL sets the post-reset level.
module ls_usb_rx_sync2 #(
    parameter int unsigned W = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages between the asynchronous lines and the logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ls_usb_rx_bytebuf.sv
// Module: byte store with one write port and a combinational read port.
// Assumes: writes are in range; out-of-range reads return zero.
module ls_usb_rx_bytebuf #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store a completed byte at its index within the packet.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the addressed byte; guard against addresses beyond the depth.
    always_comb begin
        rdata = 8'h00;
        if (32'(raddr) < DEPTH) rdata = mem[raddr];
    end
endmodule

// File: rtl/ls_usb_rx_core.sv
// Module: sync lock, bit-phase tracking, NRZI decode, unstuffing, byte
// assembly and end-of-packet handling.
// Assumes: line inputs are already synchronised; OSR is at least 4.
module ls_usb_rx_core
    import ls_usb_rx_pkg::*;
#(
    parameter int unsigned OSR      = 8,
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned MIN_LEN  = 3,
    parameter int unsigned EDGE_WIN = 10,
    localparam int unsigned PW = $clog2(OSR),
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW = $clog2(DEPTH + 1),
    localparam int unsigned WW = $clog2(EDGE_WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dp_s,
    input  logic          dm_s,
    output logic          byte_vld,
    output logic [7:0]    byte_data,
    output logic [AW-1:0] byte_idx,
    output logic          pkt_done,
    output logic [LW-1:0] pkt_len,
    output logic          ovf_err,
    output logic          sync_err
);
    localparam logic [PW-1:0] CENTER = PW'(OSR / 2);
    localparam logic [PW-1:0] PH_TOP = PW'(OSR - 1);
    localparam logic [LW-1:0] LEN_MIN = LW'(MIN_LEN);
    localparam logic [LW-1:0] LEN_CAP = LW'(DEPTH);
    localparam logic [WW-1:0] WIN_TOP = WW'(EDGE_WIN - 1);

    rx_state_t     st;
    logic          dm_d;
    logic [PW-1:0] ph;
    logic [WW-1:0] wcnt;
    logic          ksn;
    logic          prev;
    logic [2:0]    ones;
    logic [2:0]    bitcnt;
    logic [7:0]    shreg;
    logic [LW-1:0] bcnt;
    logic          se0_last;

    logic edge_dm, smp, is_j, is_k, is_se0, dbit;

    assign is_j    = dm_s & ~dp_s;
    assign is_k    = ~dm_s & dp_s;
    assign is_se0  = ~dm_s & ~dp_s;
    assign edge_dm = dm_s ^ dm_d;
    assign smp     = (ph == CENTER);
    assign dbit    = (dm_s == prev);

    // Bit-phase counter, re-aligned to one cycle past every D- transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dm_d <= 1'b1;
            ph   <= '0;
        end else begin
            dm_d <= dm_s;
            if (edge_dm)          ph <= PW'(1);
            else if (ph == PH_TOP) ph <= '0;
            else                  ph <= ph + PW'(1);
        end
    end

    // Receive state machine: sync lock, data decode and packet outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_WAITJ;
            wcnt      <= '0;
            ksn       <= 1'b0;
            prev      <= 1'b0;
            ones      <= '0;
            bitcnt    <= '0;
            shreg     <= '0;
            bcnt      <= '0;
            se0_last  <= 1'b0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            byte_idx  <= '0;
            pkt_done  <= 1'b0;
            pkt_len   <= '0;
            ovf_err   <= 1'b0;
            sync_err  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            pkt_done <= 1'b0;
            ovf_err  <= 1'b0;
            sync_err <= 1'b0;
            unique case (st)
                ST_WAITJ: if (is_j) st <= ST_ARM;
                ST_ARM: if (is_k) begin
                    st  <= ST_SYNC;
                    ksn <= 1'b0;
                end
                ST_SYNC: if (smp) begin
                    if (is_k && ksn) begin
                        st       <= ST_DATA;
                        prev     <= 1'b0;
                        ones     <= 3'd1;
                        bitcnt   <= '0;
                        bcnt     <= '0;
                        se0_last <= 1'b0;
                    end else if (is_k) begin
                        ksn <= 1'b1;
                    end else begin
                        st   <= ST_HUNT;
                        wcnt <= '0;
                    end
                end
                ST_HUNT: begin
                    if (is_k) begin
                        st  <= ST_SYNC;
                        ksn <= 1'b0;
                    end else if (wcnt == WIN_TOP) begin
                        sync_err <= 1'b1;
                        st       <= ST_WAITJ;
                    end else begin
                        wcnt <= wcnt + WW'(1);
                    end
                end
                ST_DATA: if (smp) begin
                    se0_last <= is_se0;
                    if (is_se0 && (bitcnt != 3'd0 || se0_last)) begin
                        st <= ST_WAITJ;
                        if (bcnt >= LEN_MIN) begin
                            pkt_done <= 1'b1;
                            pkt_len  <= bcnt;
                        end
                    end else begin
                        prev <= dm_s;
                        if (ones == 3'(STUFF_RUN)) begin
                            ones <= '0;
                        end else begin
                            ones   <= dbit ? ones + 3'd1 : 3'd0;
                            shreg  <= {dbit, shreg[7:1]};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                if (bcnt == LEN_CAP) begin
                                    ovf_err <= 1'b1;
                                    st      <= ST_WAITJ;
                                end else begin
                                    byte_vld  <= 1'b1;
                                    byte_data <= {dbit, shreg[7:1]};
                                    byte_idx  <= AW'(bcnt);
                                    bcnt      <= bcnt + LW'(1);
                                end
                            end
                        end
                    end
                end
                default: st <= ST_WAITJ;
            endcase
        end
    end
endmodule

// File: rtl/ls_usb_rx.sv
// Module: top of the low-speed USB packet receiver.
// Assumes: clk is OSR times the line bit rate; line inputs are asynchronous.
module ls_usb_rx #(
    parameter int unsigned OSR      = 8,
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned MIN_LEN  = 3,
    parameter int unsigned EDGE_WIN = 10,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usb_dp,
    input  logic          usb_dm,
    output logic          byte_vld,
    output logic [7:0]    byte_data,
    output logic          pkt_done,
    output logic [LW-1:0] pkt_len,
    output logic          ovf_err,
    output logic          sync_err,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [1:0]    line_s;
    logic [AW-1:0] byte_idx;

    ls_usb_rx_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({usb_dm, usb_dp}), .q(line_s)
    );

    ls_usb_rx_core #(
        .OSR(OSR), .DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .EDGE_WIN(EDGE_WIN)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .dp_s(line_s[0]), .dm_s(line_s[1]),
        .byte_vld(byte_vld), .byte_data(byte_data), .byte_idx(byte_idx),
        .pkt_done(pkt_done), .pkt_len(pkt_len),
        .ovf_err(ovf_err), .sync_err(sync_err)
    );

    ls_usb_rx_bytebuf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .we(byte_vld), .waddr(byte_idx), .wdata(byte_data),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/ls_usb_rx_chk.sv
// Module: property checker bound to the receiver top.
// Assumes: observes top-level ports only.
module ls_usb_rx_chk #(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned MIN_LEN = 3,
    parameter int unsigned LW      = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_vld,
    input logic          pkt_done,
    input logic [LW-1:0] pkt_len,
    input logic          ovf_err,
    input logic          sync_err
);
    // R1: no status pulse in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !(byte_vld || pkt_done || ovf_err || sync_err));

    // R3: byte strobe lasts one cycle
    a_r3_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    // R5: done lasts one cycle and never coincides with a byte strobe
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);
    a_r5_done_not_vld: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> !byte_vld);

    // R7: accepted packets meet the minimum length
    a_r7_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> pkt_len >= LW'(MIN_LEN));

    // R8: length never exceeds the store; no done right after overflow
    a_r8_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> pkt_len <= LW'(DEPTH));
    a_r8_no_done_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> !pkt_done);

    // R9: sync error lasts one cycle
    a_r9_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> !sync_err);
endmodule

bind ls_usb_rx ls_usb_rx_chk #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .pkt_done(pkt_done),
    .pkt_len(pkt_len), .ovf_err(ovf_err), .sync_err(sync_err)
);

// File: tb/tb_ls_usb_rx.sv
// Bench: directed scenarios, one task each, driving line levels and
// checking strobes, counts and the byte store.
module tb_ls_usb_rx;
    localparam int unsigned DEPTH = 6;
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(DEPTH + 1);
    localparam int LV_K = 0, LV_J = 1, LV_SE0 = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usb_dp = 1'b0;
    logic          usb_dm = 1'b1;
    logic          byte_vld, pkt_done, ovf_err, sync_err;
    logic [7:0]    byte_data, rd_data;
    logic [LW-1:0] pkt_len;
    logic [AW-1:0] rd_addr = '0;

    int nchecks = 0, nerr = 0;
    int nget = 0, ndone = 0, novf = 0, nsync = 0, last_len = 0;
    logic [7:0] got [0:63];
    logic [7:0] pkt [0:15];
    int cur, run;

    always #5 clk = ~clk;

    ls_usb_rx #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .byte_vld(byte_vld), .byte_data(byte_data), .pkt_done(pkt_done),
        .pkt_len(pkt_len), .ovf_err(ovf_err), .sync_err(sync_err),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Monitor: record output events away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) begin got[nget % 64] = byte_data; nget++; end
            if (pkt_done) begin ndone++; last_len = int'(pkt_len); end
            if (ovf_err) novf++;
            if (sync_err) nsync++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_lvl(input int lv, input int cyc);
        usb_dm = (lv == LV_J);
        usb_dp = (lv == LV_K);
        repeat (cyc) @(negedge clk);
    endtask

    // Sync with optional extra K J pairs before it.
    task automatic send_sync(input int per, input int pre);
        send_lvl(LV_J, 2 * per);
        for (int i = 0; i < pre; i++) begin send_lvl(LV_K, per); send_lvl(LV_J, per); end
        for (int i = 0; i < 3; i++) begin send_lvl(LV_K, per); send_lvl(LV_J, per); end
        send_lvl(LV_K, 2 * per);
        cur = LV_K; run = 1;
    endtask

    task automatic send_bytes(input int n, input int per);
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                if (pkt[i][b]) run++;
                else begin cur = (cur == LV_K) ? LV_J : LV_K; run = 0; end
                send_lvl(cur, per);
                if (run == 6) begin
                    cur = (cur == LV_K) ? LV_J : LV_K; run = 0;
                    send_lvl(cur, per);
                end
            end
    endtask

    task automatic send_eop(input int per);
        send_lvl(LV_SE0, 2 * per);
        send_lvl(LV_J, 3 * per);
    endtask

    task automatic send_packet(input int n, input int per, input int pre);
        send_sync(per, pre);
        send_bytes(n, per);
        send_eop(per);
    endtask

    // Compare received bytes since start index and the done outcome.
    task automatic expect_pkt(input string req, input int g0, input int d0,
                              input int n, input int exp_done);
        chk(req, "byte strobes", nget - g0, n);
        for (int i = 0; i < n; i++) chk(req, "byte value", int'(got[(g0 + i) % 64]), int'(pkt[i]));
        chk(req, "done pulses", ndone - d0, exp_done);
        if (exp_done != 0) chk(req, "pkt_len", last_len, n);
    endtask

    task automatic t_reset();
        chk("R1", "byte_vld", int'(byte_vld), 0);
        chk("R1", "pkt_done", int'(pkt_done), 0);
        chk("R1", "ovf_err", int'(ovf_err), 0);
        chk("R1", "sync_err", int'(sync_err), 0);
    endtask

    task automatic t_basic();
        int g0 = nget, d0 = ndone;
        pkt[0] = 8'hC3; pkt[1] = 8'h5A; pkt[2] = 8'h01;
        send_packet(3, 8, 0);
        expect_pkt("R3", g0, d0, 3, 1);  // also R2 lock and R5 length
        for (int i = 0; i < 3; i++) begin
            rd_addr = AW'(i);
            #1;
            chk("R11", "store readback", int'(rd_data), int'(pkt[i]));
        end
    endtask

    task automatic t_stuff();
        int g0 = nget, d0 = ndone;
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'hFC;
        send_packet(4, 8, 0);
        expect_pkt("R4", g0, d0, 4, 1);
    endtask

    task automatic t_short();
        int g0 = nget, d0 = ndone;
        pkt[0] = 8'hAA; pkt[1] = 8'h55;
        send_packet(2, 8, 0);
        expect_pkt("R7", g0, d0, 2, 0);
    endtask

    task automatic t_full_and_ovf();
        int g0 = nget, d0 = ndone, o0 = novf;
        for (int i = 0; i < 7; i++) pkt[i] = 8'(8'h11 * (i + 1));
        send_packet(6, 8, 0);
        expect_pkt("R8", g0, d0, 6, 1);
        g0 = nget; d0 = ndone;
        send_packet(7, 8, 0);
        expect_pkt("R8", g0, d0, 6, 0);
        chk("R8", "overflow pulses", novf - o0, 1);
    endtask

    task automatic t_sync_err();
        int g0 = nget, s0 = nsync;
        send_lvl(LV_J, 16);
        send_lvl(LV_K, 8);
        send_lvl(LV_J, 60);
        chk("R9", "sync error pulses", nsync - s0, 1);
        chk("R9", "byte strobes", nget - g0, 0);
    endtask

    task automatic t_long_sync();
        int g0 = nget, d0 = ndone, s0 = nsync;
        pkt[0] = 8'h3C; pkt[1] = 8'h96; pkt[2] = 8'hE1;
        send_packet(3, 8, 3);
        expect_pkt("R10", g0, d0, 3, 1);
        chk("R10", "no sync error", nsync - s0, 0);
    endtask

    task automatic t_drift(input int per);
        int g0 = nget, d0 = ndone;
        pkt[0] = 8'h00; pkt[1] = 8'h00; pkt[2] = 8'h00; pkt[3] = 8'h00;
        send_packet(4, per, 0);
        expect_pkt("R12", g0, d0, 4, 1);
    endtask

    // A dribble bit after the last byte is dropped; SE0 in slot 1 ends.
    task automatic t_dribble();
        int g0 = nget, d0 = ndone;
        pkt[0] = 8'h12; pkt[1] = 8'h34; pkt[2] = 8'h50;
        send_sync(8, 0);
        send_bytes(3, 8);
        send_lvl((cur == LV_K) ? LV_J : LV_K, 8);
        send_eop(8);
        expect_pkt("R5", g0, d0, 3, 1);
    endtask

    // A lone SE0 bit in slot 0 is taken as data: the packet grows to 4 bytes.
    task automatic t_se0_slot0();
        int g0 = nget, d0 = ndone;
        pkt[0] = 8'h00; pkt[1] = 8'h00; pkt[2] = 8'h00;
        send_sync(8, 0);
        send_bytes(3, 8);
        send_lvl(LV_SE0, 8);
        for (int i = 0; i < 7; i++) send_lvl((i % 2 == 0) ? LV_J : LV_K, 8);
        send_eop(8);
        chk("R6", "byte strobes", nget - g0, 4);
        chk("R6", "done pulses", ndone - d0, 1);
        chk("R6", "pkt_len", last_len, 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        repeat (8) @(negedge clk);
        t_basic();
        t_stuff();
        t_short();
        t_full_and_ovf();
        t_sync_err();
        t_long_sync();
        t_drift(9);
        t_drift(7);
        t_dribble();
        t_se0_slot0();
        repeat (20) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule